// File: doc/BRIEF.md
# Touch Sample Compare and Pen Interrupt Unit

This unit sits beside a touch-panel sampling path. Every digitized sample arrives with a two-bit tag that names the channel it came from: X, Y or the auxiliary channel U. Software picks one channel and a 16-bit threshold, and it picks which way the inequality must point. A sample on that channel that satisfies the inequality raises a compare event. A sample value equal to the threshold never raises one.

The unit also watches an asynchronous pen-touch line. The line passes through a synchronizer. It can then be qualified as a level, which is active while the line matches the programmed polarity, or as an edge, which is the transition into that polarity.

Three further event inputs come from the surrounding logic: pen-up, FIFO-full and data-ready. Each of them, like the pen-touch event, is gated by its own enable. An enabled event sets a sticky status flag. Software clears a flag by writing a one to its bit. The flags are merged onto two interrupt lines. The touch line carries the pen-touch flag. The pen-data line carries the compare, pen-up, FIFO-full and data-ready flags.

Top module: `touch_event_irq`

## Requirements
- R1: After reset, all three registers read zero and both interrupt outputs are low.
- R2: Address 0 holds the threshold in bits 15:0, the channel select in bits 17:16 and the direction in bit 18. Address 1 holds the data-ready enable in bit 1, the FIFO-full enable in bit 2, the pen enable in bit 4, the edge mode in bit 5, the polarity in bit 6 and the pen-up enable in bit 10. All other bits read 0, so writing all ones reads back 0x0007FFFF and 0x00000476. Address 3 reads 0.
- R3: The channel select uses 00 for no compare, which blocks every compare event. The codes 01, 10 and 11 select X, Y and U. These are the same codes as the sample channel tag, and a sample tagged with any other channel is ignored.
- R4: With direction 0, a compare event fires when the threshold is greater than the sample. With direction 1, it fires when the sample is greater than the threshold. A sample equal to the threshold never fires.
- R5: The status register at address 2 maps its flags as follows: bit 0 is pen-touch, bit 1 is compare, bit 2 is pen-up, bit 3 is FIFO-full and bit 4 is data-ready. A flag stays set until a write to address 2 carries a one in its bit. Writing zeros leaves the flags unchanged, and bits 31:5 read 0.
- R6: An event in the same cycle as a write-one-to-clear of its flag leaves the flag set.
- R7: The pen-up, FIFO-full, data-ready and pen-touch events set their flags only while their enable bit is 1.
- R8: In level mode (bit 5 = 0), the pen-touch flag is set on every cycle that the synchronized pen line equals the polarity bit, where 1 means high and 0 means low. A flag cleared while the line is still active therefore sets again. The flag is visible within three clock edges of the pen line changing.
- R9: In edge mode (bit 5 = 1), the pen-touch flag is set once, on the transition into the active polarity. A flag cleared while the line is held active stays clear.
- R10: touch_irq equals the pen-touch flag ANDed with the pen enable. pendata_irq is the OR of the compare flag gated by a nonzero select, and of the pen-up, FIFO-full and data-ready flags, each gated by its current enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| smp_valid | input | 1 | Sample valid |
| smp_chan | input | 2 | Sample channel tag (01 X, 10 Y, 11 U) |
| smp_data | input | 16 | Sample value |
| pen_async | input | 1 | Asynchronous pen-touch line |
| pen_up_evt | input | 1 | Pen-up event pulse |
| fifo_full_evt | input | 1 | FIFO-full event pulse |
| data_rdy_evt | input | 1 | Data-ready event pulse |
| touch_irq | output | 1 | Touch interrupt |
| pendata_irq | output | 1 | Pen-data interrupt |

## Verification
The hardest situation to reach is the collision of an event with a write-one-to-clear of its own flag. The bench raises the data-ready input and the status write on the same falling edge, so both meet at one rising edge. It then reads the flag back.

The level-versus-edge difference on the pen line is only visible after a clear made while the line is still held. For that reason, the bench clears the flag in the middle of an active period in both modes and checks whether the flag comes back.

// File: rtl/touch_irq_pkg.sv
package touch_irq_pkg;
  localparam int REG_W  = 32;
  localparam int SMP_W  = 16;
  localparam int ST_W   = 5;

  localparam logic [1:0] A_CMP  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  // control register bit positions
  localparam int B_DREN = 1;
  localparam int B_FFEN = 2;
  localparam int B_PNEN = 4;
  localparam int B_EDGE = 5;
  localparam int B_POL  = 6;
  localparam int B_PUEN = 10;

  // status flag positions
  localparam int S_PEN = 0;
  localparam int S_CMP = 1;
  localparam int S_UP  = 2;
  localparam int S_FF  = 3;
  localparam int S_DR  = 4;

  localparam logic [1:0] SEL_NONE = 2'b00;

  typedef struct packed {
    logic             dir;
    logic [1:0]       sel;
    logic [SMP_W-1:0] thr;
  } cmp_cfg_t;

  typedef struct packed {
    logic pu_en;
    logic pol;
    logic edge_md;
    logic pen_en;
    logic ff_en;
    logic dr_en;
  } ctrl_cfg_t;

  // strict inequality; equality never triggers
  function automatic logic cmp_hit_f(input logic dir,
                                     input logic [SMP_W-1:0] smp,
                                     input logic [SMP_W-1:0] thr);
    if (dir) return smp > thr;
    else     return thr > smp;
  endfunction
endpackage

// File: rtl/touch_pen_cond.sv
module touch_pen_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pen_async,
  input  logic pol,
  input  logic edge_md,
  output logic level_act,
  output logic edge_act,
  output logic pen_evt
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pen_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[TOP];

  assign level_act = (sync_q[TOP] == pol);
  assign edge_act  = level_act && (prev_q != pol);
  assign pen_evt   = edge_md ? edge_act : level_act;

  // R9
  no_double_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_act |=> (!edge_act || (pol != $past(pol))));
endmodule

// File: rtl/touch_cmp.sv
module touch_cmp
  import touch_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [1:0]       smp_chan,
  input  logic [SMP_W-1:0] smp_data,
  input  cmp_cfg_t         cfg,
  output logic             cmp_evt
);
  logic chan_match;

  assign chan_match = (cfg.sel != SEL_NONE) && (smp_chan == cfg.sel);
  assign cmp_evt    = smp_valid && chan_match && cmp_hit_f(cfg.dir, smp_data, cfg.thr);

  // R4
  equal_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_data == cfg.thr) |-> !cmp_evt);
  // R3
  no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sel == SEL_NONE) |-> !cmp_evt);
endmodule

// File: rtl/touch_regs.sv
module touch_regs
  import touch_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             pen_evt,
  input  logic             cmp_evt,
  input  logic             up_evt,
  input  logic             ff_evt,
  input  logic             dr_evt,
  output cmp_cfg_t         cmp_cfg,
  output ctrl_cfg_t        ctrl,
  output logic [ST_W-1:0]  status
);
  localparam int CMP_W = $bits(cmp_cfg_t);

  logic [ST_W-1:0] set_v, clr_v;
  logic            st_clr_wr;
  logic            unused_wbits;

  assign unused_wbits = ^reg_wdata[REG_W-1:CMP_W];

  always_comb begin
    set_v        = '0;
    set_v[S_PEN] = pen_evt & ctrl.pen_en;
    set_v[S_CMP] = cmp_evt;
    set_v[S_UP]  = up_evt  & ctrl.pu_en;
    set_v[S_FF]  = ff_evt  & ctrl.ff_en;
    set_v[S_DR]  = dr_evt  & ctrl.dr_en;
  end

  assign st_clr_wr = reg_we && (reg_addr == A_STAT);
  assign clr_v     = st_clr_wr ? reg_wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_cfg <= '0;
      ctrl    <= '0;
      status  <= '0;
    end else begin
      if (reg_we && reg_addr == A_CMP)
        cmp_cfg <= reg_wdata[CMP_W-1:0];
      if (reg_we && reg_addr == A_CTRL) begin
        ctrl.pu_en   <= reg_wdata[B_PUEN];
        ctrl.pol     <= reg_wdata[B_POL];
        ctrl.edge_md <= reg_wdata[B_EDGE];
        ctrl.pen_en  <= reg_wdata[B_PNEN];
        ctrl.ff_en   <= reg_wdata[B_FFEN];
        ctrl.dr_en   <= reg_wdata[B_DREN];
      end
      status <= (status & ~clr_v) | set_v;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMP:  reg_rdata[CMP_W-1:0] = cmp_cfg;
      A_CTRL: begin
        reg_rdata[B_PUEN] = ctrl.pu_en;
        reg_rdata[B_POL]  = ctrl.pol;
        reg_rdata[B_EDGE] = ctrl.edge_md;
        reg_rdata[B_PNEN] = ctrl.pen_en;
        reg_rdata[B_FFEN] = ctrl.ff_en;
        reg_rdata[B_DREN] = ctrl.dr_en;
      end
      A_STAT: reg_rdata[ST_W-1:0] = status;
      default: reg_rdata = '0;
    endcase
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_clr_wr |=> ((status & $past(status)) == $past(status)));
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((status & $past(set_v)) == $past(set_v)));
  // R7
  no_up_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.pu_en && !status[S_UP]) |=> !status[S_UP]);
endmodule

// File: rtl/touch_event_irq.sv
module touch_event_irq
  import touch_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             smp_valid,
  input  logic [1:0]       smp_chan,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             pen_async,
  input  logic             pen_up_evt,
  input  logic             fifo_full_evt,
  input  logic             data_rdy_evt,
  output logic             touch_irq,
  output logic             pendata_irq
);
  cmp_cfg_t        cmp_cfg;
  ctrl_cfg_t       ctrl;
  logic [ST_W-1:0] status;
  logic            cmp_evt, pen_evt, pen_level, pen_edge;

  touch_pen_cond #(.SYNC_STAGES(2)) u_pen (
    .clk(clk), .rst_n(rst_n), .pen_async(pen_async),
    .pol(ctrl.pol), .edge_md(ctrl.edge_md),
    .level_act(pen_level), .edge_act(pen_edge), .pen_evt(pen_evt)
  );

  touch_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .cfg(cmp_cfg), .cmp_evt(cmp_evt)
  );

  touch_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pen_evt(pen_evt), .cmp_evt(cmp_evt), .up_evt(pen_up_evt),
    .ff_evt(fifo_full_evt), .dr_evt(data_rdy_evt),
    .cmp_cfg(cmp_cfg), .ctrl(ctrl), .status(status)
  );

  assign touch_irq   = status[S_PEN] & ctrl.pen_en;
  assign pendata_irq = (status[S_CMP] & (cmp_cfg.sel != SEL_NONE))
                     | (status[S_UP]  & ctrl.pu_en)
                     | (status[S_FF]  & ctrl.ff_en)
                     | (status[S_DR]  & ctrl.dr_en);

  // R8
  edge_is_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pen_edge |-> pen_level);
endmodule

// File: tb/sim_touch_event_irq.sv
module sim_touch_event_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [15:0] smp_data = '0;
  logic        pen_async = 1'b0;
  logic        pen_up_evt = 1'b0, fifo_full_evt = 1'b0, data_rdy_evt = 1'b0;
  logic        touch_irq, pendata_irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  touch_event_irq u0 (.*);

  // fields: dir, sel, chan, data, thr, expected
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 2'b01, 2'b01, 16'd5,      16'd10,     1'b1},
    {1'b0, 2'b01, 2'b01, 16'd10,     16'd10,     1'b0},
    {1'b0, 2'b01, 2'b01, 16'd20,     16'd10,     1'b0},
    {1'b1, 2'b10, 2'b10, 16'd20,     16'd10,     1'b1},
    {1'b1, 2'b10, 2'b10, 16'd10,     16'd10,     1'b0},
    {1'b1, 2'b10, 2'b01, 16'd20,     16'd10,     1'b0},
    {1'b1, 2'b11, 2'b11, 16'hFFFF,   16'hFFFE,   1'b1},
    {1'b0, 2'b00, 2'b01, 16'd0,      16'hFFFF,   1'b0},
    {1'b0, 2'b11, 2'b11, 16'd0,      16'd1,      1'b1},
    {1'b1, 2'b01, 2'b11, 16'd9,      16'd0,      1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    wait_n(3); rst_n = 1'b1; @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 cmp reg", v, 0);
    rd(2'd1, v); chk("R1 ctrl reg", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    chk("R1 irqs", {30'd0, touch_irq, pendata_irq}, 0);

    // R2 field readback
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R2 cmp mask", v, 32'h0007_FFFF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R2 ctrl mask", v, 32'h0000_0476);
    rd(2'd3, v); chk("R2 addr3", v, 0);
    wr(2'd1, 0); wr(2'd0, 0); wr(2'd2, 32'h1F);

    // R3 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {13'd0, VEC[i][37], VEC[i][36:35], VEC[i][16:1]});
      wr(2'd2, 32'h1F);
      smp_valid = 1'b1; smp_chan = VEC[i][34:33]; smp_data = VEC[i][32:17];
      @(negedge clk);
      smp_valid = 1'b0;
      rd(2'd2, v);
      chk($sformatf("R3/R4 vec%0d flag", i), {31'd0, v[1]}, {31'd0, VEC[i][0]});
      chk($sformatf("R10 vec%0d pendata", i), {31'd0, pendata_irq}, {31'd0, VEC[i][0]});
    end
    wr(2'd0, 0); wr(2'd2, 32'h1F);

    // R7 disabled sources
    pen_up_evt = 1; fifo_full_evt = 1; data_rdy_evt = 1; @(negedge clk);
    pen_up_evt = 0; fifo_full_evt = 0; data_rdy_evt = 0;
    rd(2'd2, v); chk("R7 disabled no flags", v, 0);
    chk("R7 pendata off", {31'd0, pendata_irq}, 0);

    // R5 R10 enabled sources
    wr(2'd1, 32'h406);
    pen_up_evt = 1; @(negedge clk); pen_up_evt = 0;
    rd(2'd2, v); chk("R5 pen-up bit2", v, 32'h04);
    chk("R10 pendata from pen-up", {31'd0, pendata_irq}, 1);
    wr(2'd2, 32'h04); rd(2'd2, v); chk("R5 clear bit2", v, 0);
    fifo_full_evt = 1; data_rdy_evt = 1; @(negedge clk);
    fifo_full_evt = 0; data_rdy_evt = 0;
    rd(2'd2, v); chk("R5 ff+dr bits", v, 32'h18);
    wr(2'd2, 0);   rd(2'd2, v); chk("R5 zero write keeps", v, 32'h18);
    wr(2'd2, 32'h08); rd(2'd2, v); chk("R5 partial clear", v, 32'h10);

    // R6 set wins over same-cycle clear
    data_rdy_evt = 1; reg_we = 1; reg_addr = 2'd2; reg_wdata = 32'h10;
    @(negedge clk);
    data_rdy_evt = 0; reg_we = 0;
    rd(2'd2, v); chk("R6 set wins", v, 32'h10);

    // R10 gating by current enable
    wr(2'd1, 0); rd(2'd2, v); chk("R10 flag kept", v, 32'h10);
    chk("R10 pendata gated", {31'd0, pendata_irq}, 0);
    wr(2'd2, 32'h1F);

    // R8 level mode, active high
    pen_async = 0; wr(2'd1, 32'h50); wait_n(4); wr(2'd2, 32'h1F);
    rd(2'd2, v); chk("R8 idle", v, 0);
    pen_async = 1; wait_n(4);
    rd(2'd2, v); chk("R8 level flag", v, 32'h01);
    chk("R10 touch_irq", {31'd0, touch_irq}, 1);
    wr(2'd2, 32'h01); rd(2'd2, v); chk("R8 level re-flag", v, 32'h01);
    pen_async = 0; wait_n(4); wr(2'd2, 32'h1F); wait_n(1);
    rd(2'd2, v); chk("R8 released", v, 0);

    // R9 edge mode, active high
    wr(2'd1, 32'h70); wr(2'd2, 32'h1F);
    pen_async = 1; wait_n(4);
    rd(2'd2, v); chk("R9 edge flag", v, 32'h01);
    wr(2'd2, 32'h01); wait_n(3);
    rd(2'd2, v); chk("R9 no re-flag held", v, 0);
    pen_async = 0; wait_n(4);
    rd(2'd2, v); chk("R9 release no flag", v, 0);

    // R8 polarity low, edge mode
    wr(2'd1, 32'h30); wr(2'd2, 32'h1F);
    pen_async = 1; wait_n(4);
    rd(2'd2, v); chk("R8 pol0 rising ignored", v, 0);
    pen_async = 0; wait_n(4);
    rd(2'd2, v); chk("R8 pol0 falling flag", v, 32'h01);

    // R7 pen disabled
    wr(2'd1, 32'h20); wr(2'd2, 32'h1F);
    pen_async = 1; wait_n(4); pen_async = 0; wait_n(4);
    rd(2'd2, v); chk("R7 pen disabled", v, 0);
    chk("R7 touch_irq low", {31'd0, touch_irq}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule